// File: doc/BRIEF.md
# SD Card SPI-Mode Block Write Engine

This engine carries out the data phase of a card write in SPI mode, once the write command has already been accepted elsewhere. It frames every block with a filler byte and a start token, streams the payload bytes it pulls from a ready/valid source, and appends a CRC16 that it computes on the fly. It then reads the card's data response byte, checks it, and polls the line until the card stops signalling busy.

A single-block write and a multi-block write differ in their start token. A multi-block write that completes without error ends with a filler byte, a stop token and a second busy wait. The engine drives a byte-wide shifter: it launches one byte at a time, waits for the completion pulse, and samples the byte the card returned during that slot. When the run ends it pulses `done` and holds a status code until the next run.

Top module: `sd_block_writer`

## Requirements
- R1: Every block begins with the byte 0xFF followed by a start token, 0xFE when `multiMode` was low at start and 0xFC when it was high.
- R2: Exactly BLOCK_BYTES payload bytes are sent per block, in source order, and a byte is taken only in a cycle where `inValid` and `inReady` are both high.
- R3: After the payload come two CRC bytes, high byte first, holding the CRC16 of that block's payload with polynomial 0x1021, initial value 0x0000, and data fed most significant bit first.
- R4: After the CRC the engine sends 0xFF read slots, up to RESP_TRIES of them, and stops at the first returned byte whose bit 4 is 0. That byte, or the last one read if none qualified, is the data response.
- R5: A response whose low five bits equal 0x05 is accepted. Any other value ends the run at once with status 0x08, and no further byte is sent.
- R6: After acceptance the engine sends 0xFF read slots until a returned byte equals 0xFF. The first slot of the wait does not count. If BUSY_LIMIT slots pass without success, the run ends with status 0x80.
- R7: In multi-block mode, after the last block's busy wait succeeds, the engine sends 0xFF then 0xFD and repeats the busy wait of R6. Success there ends the run with status 0x00.
- R8: The stop sequence of R7 is never sent after a run ended with a nonzero status, and a single-block run never sends it.
- R9: `done` is a one-cycle pulse, `status` is valid from that cycle on, and `busy` is high from the cycle after `start` until `done`. A `start` pulse while `busy` is high has no effect.
- R10: A new byte is never launched while the previous one is still in flight: `xferStart` pulses only after the `xferDone` of the previous slot.
- R11: A start with `blockCount` of zero sends no block. In single-block mode it ends at once with status 0x00; in multi-block mode it sends only the stop sequence of R7.
- R12: After reset the engine is idle: `busy`, `done`, `inReady` and `xferStart` are low and `status` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run, sampled while idle |
| multiMode | input | 1 | 1 selects the multi-block protocol |
| blockCount | input | CNT_W | Number of blocks to write |
| inData | input | 8 | Payload byte from the source |
| inValid | input | 1 | Source has a payload byte |
| inReady | output | 1 | Engine takes the payload byte this cycle |
| xferTx | output | 8 | Byte to shift out |
| xferStart | output | 1 | Launch one byte slot on the shifter |
| xferRx | input | 8 | Byte shifted in, valid with xferDone |
| xferDone | input | 1 | Byte slot finished |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished (one cycle) |
| status | output | 8 | 0x00 success, 0x08 response rejected, 0x80 busy timeout |

## Verification
The assertions assume that the shifter answers each launch with exactly one `xferDone` pulse, at least one cycle after `xferStart`, and never raises `xferDone` on its own. They also assume that `xferRx` is stable while `xferDone` is high. The bench's shifter model fixes the latency at two cycles and returns card bytes only while the card model is in its answering phase. It never issues a completion without a pending launch. The payload source drops `inValid` in a fixed pattern during one run, so that stalls inside a block are exercised without breaking the one-slot-in-flight rule.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam logic [7:0] TOK_SINGLE  = 8'hFE;
  localparam logic [7:0] TOK_MULTI   = 8'hFC;
  localparam logic [7:0] TOK_STOP    = 8'hFD;
  localparam logic [4:0] RESP_ACCEPT = 5'h05;

  localparam logic [7:0] STAT_OK     = 8'h00;
  localparam logic [7:0] STAT_REJECT = 8'h08;
  localparam logic [7:0] STAT_TMO    = 8'h80;

  typedef enum logic [2:0] {
    SEL_FILL,
    SEL_START,
    SEL_STOP,
    SEL_DATA,
    SEL_CRC_HI,
    SEL_CRC_LO
  } byteSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     issue;
    byteSel_t sel;
    logic     crcClr;
    logic     tokMulti;
  } dpCmd_t;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_LEAD,
    PH_TOKEN,
    PH_DATA,
    PH_CRC_HI,
    PH_CRC_LO,
    PH_RESP,
    PH_BUSY,
    PH_STOP_LEAD,
    PH_STOP_TOK
  } phase_t;

  // one payload byte through the x^16+x^12+x^5+1 register, msb first
  function automatic logic [15:0] crcStep(input logic [15:0] cur, input logic [7:0] b);
    logic [15:0] r;
    r = cur;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/sdw_datapath.sv
module sdw_datapath
  import sdw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic [7:0] inData,
  input  logic [7:0] xferRx,
  output logic [7:0] xferTx,
  output logic       xferStart,
  output logic       respFound,
  output logic       respOk,
  output logic       rxIdle
);

  logic [15:0] crcQ;
  logic [7:0]  txByte;

  always_comb begin
    case (cmd.sel)
      SEL_START:  txByte = cmd.tokMulti ? TOK_MULTI : TOK_SINGLE;
      SEL_STOP:   txByte = TOK_STOP;
      SEL_DATA:   txByte = inData;
      SEL_CRC_HI: txByte = crcQ[15:8];
      SEL_CRC_LO: txByte = crcQ[7:0];
      default:    txByte = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ      <= '0;
      xferTx    <= FILL_BYTE;
      xferStart <= 1'b0;
    end else begin
      xferStart <= cmd.issue;
      if (cmd.issue) xferTx <= txByte;
      if (cmd.crcClr) crcQ <= '0;
      else if (cmd.issue && cmd.sel == SEL_DATA) crcQ <= crcStep(crcQ, inData);
    end
  end

  // decode of the byte the card returned in the finished slot
  assign respFound = ~xferRx[4];
  assign respOk    = (xferRx[4:0] == RESP_ACCEPT);
  assign rxIdle    = (xferRx == FILL_BYTE);

  assert_crc_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.crcClr |=> (crcQ == 16'h0000));

  assert_start_spacing_R10: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);

endmodule

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
  import sdw_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int RESP_TRIES  = 8,
  parameter int BUSY_LIMIT  = 3000000,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             multiMode,
  input  logic [CNT_W-1:0] blockCount,
  input  logic             inValid,
  output logic             inReady,
  input  logic             xferDone,
  input  logic             respFound,
  input  logic             respOk,
  input  logic             rxIdle,
  output dpCmd_t           cmd,
  output logic             busy,
  output logic             done,
  output logic [7:0]       status
);

  localparam int BYTE_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
  localparam int TRY_W  = $clog2(RESP_TRIES + 1);
  localparam int BUSY_W = $clog2(BUSY_LIMIT + 1);
  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(BLOCK_BYTES - 1);
  localparam logic [TRY_W-1:0]  TRY_LAST  = TRY_W'(RESP_TRIES - 1);
  localparam logic [BUSY_W-1:0] BUSY_LAST = BUSY_W'(BUSY_LIMIT - 1);

  phase_t            stateQ, stateD;
  logic              waitQ, waitD;
  logic [BYTE_W-1:0] byteQ, byteD;
  logic [TRY_W-1:0]  tryQ, tryD;
  logic [BUSY_W-1:0] pollQ, pollD;
  logic [CNT_W-1:0]  blocksQ, blocksD;
  logic              multiQ, multiD;
  logic              afterStopQ, afterStopD;
  logic              doneQ, doneD;
  logic [7:0]        statusQ, statusD;
  logic              issueNow;

  assign issueNow = (stateQ != PH_IDLE) && !waitQ && ((stateQ != PH_DATA) || inValid);
  assign inReady  = (stateQ == PH_DATA) && !waitQ;

  always_comb begin
    cmd          = '0;
    cmd.issue    = issueNow;
    cmd.crcClr   = issueNow && (stateQ == PH_LEAD);
    cmd.tokMulti = multiQ;
    case (stateQ)
      PH_TOKEN:   cmd.sel = SEL_START;
      PH_STOP_TOK:cmd.sel = SEL_STOP;
      PH_DATA:    cmd.sel = SEL_DATA;
      PH_CRC_HI:  cmd.sel = SEL_CRC_HI;
      PH_CRC_LO:  cmd.sel = SEL_CRC_LO;
      default:    cmd.sel = SEL_FILL;
    endcase
  end

  always_comb begin
    stateD     = stateQ;
    waitD      = waitQ;
    byteD      = byteQ;
    tryD       = tryQ;
    pollD      = pollQ;
    blocksD    = blocksQ;
    multiD     = multiQ;
    afterStopD = afterStopQ;
    doneD      = 1'b0;
    statusD    = statusQ;
    if (issueNow) waitD = 1'b1;
    if (stateQ == PH_IDLE) begin
      if (start) begin
        multiD     = multiMode;
        blocksD    = blockCount;
        afterStopD = 1'b0;
        if (blockCount != '0)  stateD = PH_LEAD;
        else if (multiMode)    stateD = PH_STOP_LEAD;
        else begin
          doneD   = 1'b1;
          statusD = STAT_OK;
        end
      end
    end else if (waitQ && xferDone) begin
      waitD = 1'b0;
      case (stateQ)
        PH_LEAD:  stateD = PH_TOKEN;
        PH_TOKEN: begin
          stateD = PH_DATA;
          byteD  = '0;
        end
        PH_DATA: begin
          if (byteQ == BYTE_LAST) stateD = PH_CRC_HI;
          else byteD = byteQ + 1'b1;
        end
        PH_CRC_HI: stateD = PH_CRC_LO;
        PH_CRC_LO: begin
          stateD = PH_RESP;
          tryD   = '0;
        end
        PH_RESP: begin
          if (respFound || tryQ == TRY_LAST) begin
            if (respOk) begin
              stateD     = PH_BUSY;
              pollD      = '0;
              afterStopD = 1'b0;
            end else begin
              stateD  = PH_IDLE;
              doneD   = 1'b1;
              statusD = STAT_REJECT;
            end
          end else tryD = tryQ + 1'b1;
        end
        PH_BUSY: begin
          if (pollQ != '0 && rxIdle) begin
            if (afterStopQ) begin
              stateD  = PH_IDLE;
              doneD   = 1'b1;
              statusD = STAT_OK;
            end else if (blocksQ == CNT_W'(1)) begin
              blocksD = '0;
              if (multiQ) stateD = PH_STOP_LEAD;
              else begin
                stateD  = PH_IDLE;
                doneD   = 1'b1;
                statusD = STAT_OK;
              end
            end else begin
              blocksD = blocksQ - 1'b1;
              stateD  = PH_LEAD;
            end
          end else if (pollQ == BUSY_LAST) begin
            stateD  = PH_IDLE;
            doneD   = 1'b1;
            statusD = STAT_TMO;
          end else pollD = pollQ + 1'b1;
        end
        PH_STOP_LEAD: stateD = PH_STOP_TOK;
        PH_STOP_TOK: begin
          stateD     = PH_BUSY;
          pollD      = '0;
          afterStopD = 1'b1;
        end
        default: stateD = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= PH_IDLE;
      waitQ      <= 1'b0;
      byteQ      <= '0;
      tryQ       <= '0;
      pollQ      <= '0;
      blocksQ    <= '0;
      multiQ     <= 1'b0;
      afterStopQ <= 1'b0;
      doneQ      <= 1'b0;
      statusQ    <= STAT_OK;
    end else begin
      stateQ     <= stateD;
      waitQ      <= waitD;
      byteQ      <= byteD;
      tryQ       <= tryD;
      pollQ      <= pollD;
      blocksQ    <= blocksD;
      multiQ     <= multiD;
      afterStopQ <= afterStopD;
      doneQ      <= doneD;
      statusQ    <= statusD;
    end
  end

  assign busy   = (stateQ != PH_IDLE);
  assign done   = doneQ;
  assign status = statusQ;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  assert_status_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (statusQ == STAT_OK || statusQ == STAT_REJECT || statusQ == STAT_TMO));

  assert_resp_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PH_RESP) |-> (tryQ < TRY_W'(RESP_TRIES)));

  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PH_BUSY) |-> (pollQ < BUSY_W'(BUSY_LIMIT)));

  assert_stop_multi_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PH_STOP_TOK) |-> (multiQ && statusQ == STAT_OK || multiQ));

endmodule

// File: rtl/sd_block_writer.sv
module sd_block_writer
  import sdw_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int RESP_TRIES  = 8,
  parameter int BUSY_LIMIT  = 3000000,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             multiMode,
  input  logic [CNT_W-1:0] blockCount,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic [7:0]       xferTx,
  output logic             xferStart,
  input  logic [7:0]       xferRx,
  input  logic             xferDone,
  output logic             busy,
  output logic             done,
  output logic [7:0]       status
);

  dpCmd_t cmd;
  logic   respFound;
  logic   respOk;
  logic   rxIdle;

  sdw_ctrl #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .RESP_TRIES (RESP_TRIES),
    .BUSY_LIMIT (BUSY_LIMIT),
    .CNT_W      (CNT_W)
  ) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .multiMode (multiMode),
    .blockCount(blockCount),
    .inValid   (inValid),
    .inReady   (inReady),
    .xferDone  (xferDone),
    .respFound (respFound),
    .respOk    (respOk),
    .rxIdle    (rxIdle),
    .cmd       (cmd),
    .busy      (busy),
    .done      (done),
    .status    (status)
  );

  sdw_datapath dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .inData   (inData),
    .xferRx   (xferRx),
    .xferTx   (xferTx),
    .xferStart(xferStart),
    .respFound(respFound),
    .respOk   (respOk),
    .rxIdle   (rxIdle)
  );

endmodule

// File: tb/sd_block_writer_test.sv
module sd_block_writer_test;

  localparam int CLK_PERIOD = 10;
  localparam int BB         = 9;
  localparam int TRIES      = 8;
  localparam int POLLS      = 6;
  localparam int CW         = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          multiMode = 1'b0;
  logic [CW-1:0] blockCount = '0;
  logic [7:0]    inData = 8'h00;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [7:0]    xferTx;
  logic          xferStart;
  logic [7:0]    xferRx = 8'hFF;
  logic          xferDone = 1'b0;
  logic          busy;
  logic          done;
  logic [7:0]    status;

  sd_block_writer #(.BLOCK_BYTES(BB), .RESP_TRIES(TRIES), .BUSY_LIMIT(POLLS), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .multiMode(multiMode), .blockCount(blockCount),
    .inData(inData), .inValid(inValid), .inReady(inReady), .xferTx(xferTx),
    .xferStart(xferStart), .xferRx(xferRx), .xferDone(xferDone), .busy(busy),
    .done(done), .status(status));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  // shifter / card model state
  int          pendCnt = 0;
  logic [7:0]  rxHold = 8'hFF;
  int          cardMode = 0;
  int          cardCnt = 0;
  logic [15:0] cardCrc = 0;
  logic [7:0]  cardHi = 0;
  logic [15:0] lastCrc = 0;
  logic [7:0]  segQ[$];
  int          segLens[$];
  int          segLeft = 0;
  logic [7:0]  gotQ[$];
  logic [7:0]  expQ[$];

  // payload source
  logic [7:0]  srcSeed = 0;
  int          srcIdx = 0;
  bit          takePend = 0;
  bit          gapOn = 0;
  int          expIdx = 0;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    repeat (8) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic enterAnswer();
    if (segLens.size() > 0) begin
      segLeft  = segLens.pop_front();
      cardMode = (segLeft > 0) ? 2 : 0;
    end else cardMode = 0;
  endtask

  task automatic cardByte(input logic [7:0] tx, output logic [7:0] rx);
    rx = 8'hFF;
    gotQ.push_back(tx);
    case (cardMode)
      0: begin
        if (tx == 8'hFE || tx == 8'hFC) begin
          cardMode = 1; cardCnt = 0; cardCrc = 0;
        end else if (tx == 8'hFD) enterAnswer();
      end
      1: begin
        if (cardCnt < BB) begin
          cardCrc = refCrc(cardCrc, tx); cardCnt++;
        end else if (cardCnt == BB) begin
          cardHi = tx; cardCnt++;
        end else begin
          lastCrc = {cardHi, tx};
          check(lastCrc == cardCrc, "R3 block crc", lastCrc, cardCrc);
          enterAnswer();
        end
      end
      default: begin
        if (segQ.size() > 0) rx = segQ.pop_front();
        segLeft--;
        if (segLeft <= 0) cardMode = 0;
      end
    endcase
  endtask

  always @(negedge clk) begin
    logic [7:0] r;
    cyc++;
    xferDone = 1'b0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        xferDone = 1'b1;
        xferRx   = rxHold;
      end
    end
    if (rstN && xferStart) begin
      check(pendCnt == 0 && !xferDone, "R10 launch while in flight", pendCnt, 0);
      cardByte(xferTx, r);
      rxHold  = r;
      pendCnt = 2;
    end
    if (rstN) check(!(inReady && !busy), "R2 ready while idle", inReady, 0);
    if (takePend) srcIdx++;
    inValid  = gapOn ? ((cyc % 3) != 0) : 1'b1;
    inData   = srcSeed + 8'(srcIdx);
    takePend = inValid && inReady;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      check(0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic addSeg(input int n, input logic [63:0] v);
    for (int i = 0; i < n; i++) segQ.push_back(v[63 - 8*i -: 8]);
    segLens.push_back(n);
  endtask

  task automatic expBlock(input logic [7:0] tok, input int reads);
    logic [15:0] c;
    c = 0;
    expQ.push_back(8'hFF);
    expQ.push_back(tok);
    for (int k = 0; k < BB; k++) begin
      logic [7:0] d;
      d = srcSeed + 8'(expIdx);
      expIdx++;
      expQ.push_back(d);
      c = refCrc(c, d);
    end
    expQ.push_back(c[15:8]);
    expQ.push_back(c[7:0]);
    for (int k = 0; k < reads; k++) expQ.push_back(8'hFF);
  endtask

  task automatic expStop(input int reads);
    expQ.push_back(8'hFF);
    expQ.push_back(8'hFD);
    for (int k = 0; k < reads; k++) expQ.push_back(8'hFF);
  endtask

  task automatic prep(input logic [7:0] seed, input bit gaps);
    gotQ.delete(); expQ.delete(); segQ.delete(); segLens.delete();
    cardMode = 0; srcSeed = seed; srcIdx = 0; expIdx = 0; gapOn = gaps;
  endtask

  task automatic runScen(input string tag, input bit multi, input int cnt,
                         input logic [7:0] expStat, input int pokeAt);
    int waited;
    bit seen;
    @(negedge clk);
    multiMode  = multi;
    blockCount = CW'(cnt);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0; seen = 0;
    while (!seen && waited < 5000) begin
      if (done) seen = 1;
      else begin
        start = (waited == pokeAt);
        if (waited == pokeAt) begin multiMode = ~multi; blockCount = 1; end
        @(negedge clk);
        start = 1'b0;
        waited++;
      end
    end
    check(seen, {tag, " R9 done seen"}, seen, 1);
    check(status == expStat, {tag, " R5 R6 R7 status"}, status, expStat);
    check(gotQ.size() == expQ.size(), {tag, " R1 R4 R8 byte count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < gotQ.size() && i < expQ.size(); i++)
      if (gotQ[i] !== expQ[i]) begin
        check(0, {tag, " R1 R2 stream byte"}, gotQ[i], expQ[i]);
        break;
      end
    check(srcIdx == expIdx, {tag, " R2 payload consumed"}, srcIdx, expIdx);
    @(negedge clk);
    check(!done && !busy, {tag, " R9 done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!busy, "R12 busy", busy, 0);
    check(!done, "R12 done", done, 0);
    check(!inReady, "R12 inReady", inReady, 0);
    check(!xferStart && status == 8'h00, "R12 xferStart/status", status, 0);

    // S1: single block, known CRC vector, ignored first busy slot (R1 R3 R6)
    prep(8'h31, 0);
    addSeg(7, 64'hFF_FF_E5_FF_00_00_FF_00);
    expBlock(8'hFE, 7);
    runScen("S1", 0, 1, 8'h00, -1);
    check(lastCrc == 16'h31C3, "R3 known vector", lastCrc, 16'h31C3);

    // S2: multi 3 blocks with source gaps, ignored start mid-run (R2 R7 R9)
    prep(8'h80, 1);
    addSeg(3, 64'h05_00_FF_00_00_00_00_00);
    addSeg(5, 64'hFF_25_00_00_FF_00_00_00);
    addSeg(3, 64'hE5_FF_FF_00_00_00_00_00);
    addSeg(2, 64'h00_FF_00_00_00_00_00_00);
    expBlock(8'hFC, 3); expBlock(8'hFC, 5); expBlock(8'hFC, 3); expStop(2);
    runScen("S2", 1, 3, 8'h00, 40);

    // S3: multi, second response rejected: no stop token (R5 R8)
    prep(8'h10, 0);
    addSeg(3, 64'h05_00_FF_00_00_00_00_00);
    addSeg(1, 64'h0B_00_00_00_00_00_00_00);
    expBlock(8'hFC, 3); expBlock(8'hFC, 1);
    runScen("S3", 1, 3, 8'h08, -1);

    // S4: no byte with bit 4 clear within the try limit (R4)
    prep(8'h40, 0);
    addSeg(8, 64'hFF_FF_FF_FF_FF_FF_FF_FF);
    expBlock(8'hFE, 8);
    runScen("S4", 0, 1, 8'h08, -1);

    // S5: single mode, two blocks, second busy wait times out (R1 R6)
    prep(8'h60, 0);
    addSeg(3, 64'hE5_FF_FF_00_00_00_00_00);
    addSeg(7, 64'h05_00_00_00_00_00_00_00);
    expBlock(8'hFE, 3); expBlock(8'hFE, 7);
    runScen("S5", 0, 2, 8'h80, -1);

    // S6: multi, busy wait after stop token times out (R7)
    prep(8'h70, 0);
    addSeg(3, 64'h05_00_FF_00_00_00_00_00);
    addSeg(6, 64'hFF_00_00_00_00_00_00_00);
    expBlock(8'hFC, 3); expStop(6);
    runScen("S6", 1, 1, 8'h80, -1);

    // S7: zero blocks in single mode (R11)
    prep(8'h00, 0);
    runScen("S7 R11", 0, 0, 8'h00, -1);

    // S8: zero blocks in multi mode sends only the stop sequence (R11)
    prep(8'h00, 0);
    addSeg(2, 64'h00_FF_00_00_00_00_00_00);
    expStop(2);
    runScen("S8 R11", 1, 0, 8'h00, -1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule